// File: doc/BRIEF.md
# Wavefront Issue Scheduler for a Four-Pipeline Compute Cluster

This block picks, every clock cycle, which resident wavefront of a compute cluster sends its next instruction to execution. The cluster has four vector pipelines that share one scalar pipeline. Each vector pipeline owns a pool of wavefront slots. A vector instruction keeps its 16-lane pipeline busy for four cycles, so the pipelines take turns in a fixed rotation. In each cycle only the pipeline whose turn it is may issue, and it may issue one vector-class and one scalar-class instruction from two different slots.

The choice is made in hardware as the program runs. A slot is a candidate when it is resident, its next instruction is available, its dependency check is clear and it has no earlier instruction still outstanding. Among the candidates the longest-resident wavefront wins. A stalled wavefront is passed over in favour of any other ready one, whatever task each belongs to. A per-slot outstanding flag enforces program order within a wavefront. The flag is set when the slot issues and is cleared by a completion pulse from execution. Turns in which the pipeline has nothing to issue are counted.

Top module: `wis_issue_sched`

## Requirements
- R1: While rst_n is low, vec_grant and sc_grant are 0 and idle_count is 0. In the first cycle after release, pipeline 0 has the turn.
- R2: The turn rotates 0,1,2,3,0,... one step per cycle. Any grant carries the current turn in vec_simd or sc_simd.
- R3: Slot s of pipeline k uses bit k*10+s of every per-slot input. It qualifies only when slot_valid, slot_ready and slot_dep_clear are all 1 and its outstanding flag is clear.
- R4: Age is 0 in the first cycle a slot is seen valid. It rises by 1 each cycle the slot stays valid, saturates at 63, and returns to 0 when slot_valid is 0. The vector grant goes to the qualified vector-class slot of the turn pipeline with the largest age. A tie goes to the lowest slot index.
- R5: slot_scalar=1 marks the next instruction as scalar class (control flow, one-off integer work). Such a slot is granted only on the scalar port, using the same age and index ordering. A vector-class slot (slot_scalar=0) is granted only on the vector port. Both grants may fire in one cycle, from different slots of the same pipeline.
- R6: Issuing sets the slot's outstanding flag, so it cannot be granted again until a slot_done pulse arrives. A slot_done for a slot with no outstanding instruction has no effect. A slot that goes invalid drops its flag.
- R7: A stalled slot, even the oldest one, never blocks a younger qualified slot of the same pipeline from being granted.
- R8: idle_count increases by 1 after each cycle in which the turn pipeline has no qualified slot. It saturates at 65535. When no grant fires, vec_simd, vec_slot, sc_simd and sc_slot are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid | input | 40 | Slot holds a resident wavefront |
| slot_ready | input | 40 | Next instruction of the slot is available |
| slot_scalar | input | 40 | Class of next instruction, 1 = scalar |
| slot_dep_clear | input | 40 | Operands of next instruction are free of hazards |
| slot_done | input | 40 | Completion pulse for the outstanding instruction |
| vec_grant | output | 1 | A vector instruction issues this cycle |
| vec_simd | output | 2 | Pipeline of the vector grant |
| vec_slot | output | 4 | Slot of the vector grant |
| sc_grant | output | 1 | A scalar instruction issues this cycle |
| sc_simd | output | 2 | Pipeline of the scalar grant |
| sc_slot | output | 4 | Slot of the scalar grant |
| idle_count | output | 16 | Turns with nothing to issue |

## Verification
In the first pattern, every slot is made resident at a staggered time and completes at once. This separates age ordering from index ordering, and because it runs long enough for ages to saturate, it also exposes the lowest-index tie break. A pattern with sparse dependency clears checks that a stalled old slot is skipped and not waited on. A pattern without completion pulses fills every outstanding flag and then drives the idle counter, with stray completions for idle slots mixed in. Mixed-class and churning-residency patterns test the split between the scalar and vector ports and the clearing of age and flags on eviction.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int unsigned DEF_SIMDS  = 4;
  localparam int unsigned DEF_SLOTS  = 10;
  localparam int unsigned DEF_AGE_W  = 6;
  localparam int unsigned DEF_IDLE_W = 16;

  typedef enum logic {
    CLS_VECTOR = 1'b0,
    CLS_SCALAR = 1'b1
  } instr_class_e;

  // A slot may be chosen when resident, fetched, hazard-free and not waiting.
  function automatic logic slot_qualifies(logic valid, logic ready,
                                          logic dep_ok, logic waiting);
    return valid & ready & dep_ok & ~waiting;
  endfunction

  // Candidate replaces the current best only when strictly older.
  function automatic logic prefers(logic have_best, int unsigned best_age,
                                   int unsigned cand_age);
    return !have_best || (cand_age > best_age);
  endfunction

  function automatic int unsigned next_turn(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  function automatic logic class_match(logic scalar_bit, instr_class_e want);
    return (instr_class_e'(scalar_bit) == want);
  endfunction
endpackage

// File: rtl/wis_slot_state.sv
module wis_slot_state #(
  parameter int unsigned TOTAL = 40,
  parameter int unsigned AGE_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TOTAL-1:0]              valid,
  input  logic [TOTAL-1:0]              issue,
  input  logic [TOTAL-1:0]              done,
  output logic [TOTAL-1:0]              pending,
  output logic [TOTAL-1:0][AGE_W-1:0]   age
);
  for (genvar i = 0; i < TOTAL; i++) begin : g_slot
    logic             pend_r;
    logic [AGE_W-1:0] age_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_r <= 1'b0;
        age_r  <= '0;
      end else if (!valid[i]) begin
        pend_r <= 1'b0;
        age_r  <= '0;
      end else begin
        if (age_r != '1) age_r <= age_r + 1'b1;
        if (issue[i])     pend_r <= 1'b1;
        else if (done[i]) pend_r <= 1'b0;
      end
    end

    assign pending[i] = pend_r;
    assign age[i]     = age_r;
  end
endmodule

// File: rtl/wis_turn.sv
module wis_turn #(
  parameter int unsigned NUM_SIMD = 4,
  parameter int unsigned IDLE_W   = 16,
  localparam int unsigned SIMD_W  = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_evt,
  output logic [SIMD_W-1:0] turn,
  output logic [IDLE_W-1:0] idle_count
);
  import wis_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn       <= '0;
      idle_count <= '0;
    end else begin
      turn <= SIMD_W'(next_turn(int'(turn), NUM_SIMD));
      if (idle_evt && idle_count != '1) idle_count <= idle_count + 1'b1;
    end
  end
endmodule

// File: rtl/wis_pick.sv
module wis_pick #(
  parameter int unsigned SLOTS = 10,
  parameter int unsigned AGE_W = 6,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0]            cand,
  input  logic [SLOTS-1:0][AGE_W-1:0] age,
  output logic                        found,
  output logic [SLOT_W-1:0]           idx
);
  import wis_pkg::*;

  logic [AGE_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int j = 0; j < SLOTS; j++) begin
      if (cand[j] && prefers(found, int'(best), int'(age[j]))) begin
        found = 1'b1;
        idx   = SLOT_W'(j);
        best  = age[j];
      end
    end
  end
endmodule

// File: rtl/wis_issue_sched.sv
module wis_issue_sched #(
  parameter int unsigned NUM_SIMD = wis_pkg::DEF_SIMDS,
  parameter int unsigned SLOTS    = wis_pkg::DEF_SLOTS,
  parameter int unsigned AGE_W    = wis_pkg::DEF_AGE_W,
  parameter int unsigned IDLE_W   = wis_pkg::DEF_IDLE_W,
  localparam int unsigned TOTAL   = NUM_SIMD * SLOTS,
  localparam int unsigned SIMD_W  = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
  localparam int unsigned SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TOTAL-1:0]  slot_valid,
  input  logic [TOTAL-1:0]  slot_ready,
  input  logic [TOTAL-1:0]  slot_scalar,
  input  logic [TOTAL-1:0]  slot_dep_clear,
  input  logic [TOTAL-1:0]  slot_done,
  output logic              vec_grant,
  output logic [SIMD_W-1:0] vec_simd,
  output logic [SLOT_W-1:0] vec_slot,
  output logic              sc_grant,
  output logic [SIMD_W-1:0] sc_simd,
  output logic [SLOT_W-1:0] sc_slot,
  output logic [IDLE_W-1:0] idle_count
);
  import wis_pkg::*;

  // Named internal events, visible to the bound checker
  logic [SIMD_W-1:0]              turn;
  logic [TOTAL-1:0]               pending;
  logic [TOTAL-1:0][AGE_W-1:0]    age_all;
  logic [TOTAL-1:0]               qual;
  logic [TOTAL-1:0]               issue_mask;
  logic [SLOTS-1:0]               vcand, scand;
  logic [SLOTS-1:0][AGE_W-1:0]    turn_age;
  logic                           vfound, sfound;
  logic [SLOT_W-1:0]              vidx, sidx;
  logic                           idle_evt;

  wis_slot_state #(.TOTAL(TOTAL), .AGE_W(AGE_W)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (slot_valid),
    .issue   (issue_mask),
    .done    (slot_done),
    .pending (pending),
    .age     (age_all)
  );

  wis_turn #(.NUM_SIMD(NUM_SIMD), .IDLE_W(IDLE_W)) u_turn (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_evt   (idle_evt),
    .turn       (turn),
    .idle_count (idle_count)
  );

  always_comb begin
    for (int i = 0; i < TOTAL; i++)
      qual[i] = slot_qualifies(slot_valid[i], slot_ready[i],
                               slot_dep_clear[i], pending[i]);
  end

  // Gather the slots of the pipeline whose turn it is
  always_comb begin
    int base;
    base = int'(turn) * SLOTS;
    for (int j = 0; j < SLOTS; j++) begin
      vcand[j]    = qual[base+j] & class_match(slot_scalar[base+j], CLS_VECTOR);
      scand[j]    = qual[base+j] & class_match(slot_scalar[base+j], CLS_SCALAR);
      turn_age[j] = age_all[base+j];
    end
  end

  wis_pick #(.SLOTS(SLOTS), .AGE_W(AGE_W)) u_vpick (
    .cand  (vcand),
    .age   (turn_age),
    .found (vfound),
    .idx   (vidx)
  );

  wis_pick #(.SLOTS(SLOTS), .AGE_W(AGE_W)) u_spick (
    .cand  (scand),
    .age   (turn_age),
    .found (sfound),
    .idx   (sidx)
  );

  assign vec_grant = rst_n & vfound;
  assign sc_grant  = rst_n & sfound;
  assign vec_simd  = vec_grant ? turn : '0;
  assign vec_slot  = vec_grant ? vidx : '0;
  assign sc_simd   = sc_grant  ? turn : '0;
  assign sc_slot   = sc_grant  ? sidx : '0;
  assign idle_evt  = rst_n & ~(vfound | sfound);

  always_comb begin
    int base;
    base = int'(turn) * SLOTS;
    for (int i = 0; i < TOTAL; i++)
      issue_mask[i] = (vec_grant && i == base + int'(vidx)) ||
                      (sc_grant  && i == base + int'(sidx));
  end
endmodule

// File: rtl/wis_issue_sched_chk.sv
module wis_issue_sched_chk #(
  parameter int unsigned NUM_SIMD = 4,
  parameter int unsigned SLOTS    = 10,
  parameter int unsigned IDLE_W   = 16,
  localparam int unsigned TOTAL   = NUM_SIMD * SLOTS,
  localparam int unsigned SIMD_W  = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
  localparam int unsigned SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TOTAL-1:0]  slot_valid,
  input logic [TOTAL-1:0]  slot_ready,
  input logic [TOTAL-1:0]  slot_scalar,
  input logic [TOTAL-1:0]  slot_dep_clear,
  input logic              vec_grant,
  input logic [SIMD_W-1:0] vec_simd,
  input logic [SLOT_W-1:0] vec_slot,
  input logic              sc_grant,
  input logic [SIMD_W-1:0] sc_simd,
  input logic [SLOT_W-1:0] sc_slot,
  input logic [IDLE_W-1:0] idle_count
);
  int unsigned ph;
  int          vg_idx, sg_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 0;
    else        ph <= (ph + 1 >= NUM_SIMD) ? 0 : ph + 1;
  end

  always_comb begin
    vg_idx = (int'(vec_slot) < SLOTS) ? int'(vec_simd) * SLOTS + int'(vec_slot) : 0;
    sg_idx = (int'(sc_slot)  < SLOTS) ? int'(sc_simd)  * SLOTS + int'(sc_slot)  : 0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!vec_grant && !sc_grant && idle_count == '0));

  // R2
  vec_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_grant |-> (int'(vec_simd) == int'(ph)));

  // R2
  sc_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_grant |-> (int'(sc_simd) == int'(ph)));

  // R3
  vec_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_grant |-> (int'(vec_slot) < SLOTS && slot_valid[vg_idx] &&
                   slot_ready[vg_idx] && slot_dep_clear[vg_idx]));

  // R3
  sc_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_grant |-> (int'(sc_slot) < SLOTS && slot_valid[sg_idx] &&
                  slot_ready[sg_idx] && slot_dep_clear[sg_idx]));

  // R5
  vec_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_grant |-> !slot_scalar[vg_idx]);

  // R5
  sc_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_grant |-> slot_scalar[sg_idx]);

  // R5
  dual_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_grant && sc_grant) |-> (vec_simd == sc_simd && vec_slot != sc_slot));

  // R8
  idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_grant && !sc_grant && idle_count != '1) |=>
      (idle_count == IDLE_W'($past(idle_count) + 1'b1)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_grant || sc_grant) |=> $stable(idle_count));

  // R8
  quiet_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_grant |-> (vec_simd == '0 && vec_slot == '0)) and
    (!sc_grant  |-> (sc_simd  == '0 && sc_slot  == '0)));
endmodule

bind wis_issue_sched wis_issue_sched_chk #(
  .NUM_SIMD (NUM_SIMD),
  .SLOTS    (SLOTS),
  .IDLE_W   (IDLE_W)
) chk_i (.*);

// File: tb/wis_issue_sched_tb_top.sv
module wis_issue_sched_tb_top;
  localparam int NS = 4, NSL = 10, NT = 40, AGE_MAX = 63, IDLE_MAX = 65535;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0] s_valid, s_ready, s_scalar, s_dep, s_done;
  logic vec_grant, sc_grant;
  logic [1:0] vec_simd, sc_simd;
  logic [3:0] vec_slot, sc_slot;
  logic [15:0] idle_count;

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur_tag = "R4";

  // reference model state
  int  m_age[NT];
  bit  m_pend[NT];
  int  m_turn, m_idle, cyc;

  always #5 clk = ~clk;

  wis_issue_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .slot_valid(s_valid), .slot_ready(s_ready), .slot_scalar(s_scalar),
    .slot_dep_clear(s_dep), .slot_done(s_done),
    .vec_grant(vec_grant), .vec_simd(vec_simd), .vec_slot(vec_slot),
    .sc_grant(sc_grant), .sc_simd(sc_simd), .sc_slot(sc_slot),
    .idle_count(idle_count)
  );

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  // Pick by residency: oldest wins, earliest index wins ties (R4, R5)
  function automatic int choose(bit want_scalar);
    int q[$];
    int win = -1;
    for (int s = 0; s < NSL; s++) begin
      int f = m_turn * NSL + s;
      if (s_valid[f] && s_ready[f] && s_dep[f] && !m_pend[f] && (s_scalar[f] == want_scalar))
        q.push_back(s);
    end
    foreach (q[k])
      if (win < 0 || m_age[m_turn*NSL+q[k]] > m_age[m_turn*NSL+win]) win = q[k];
    return win;
  endfunction

  task automatic compare_and_step();
    int ev = choose(1'b0);
    int es = choose(1'b1);
    check("R2", int'(vec_grant), int'(ev >= 0), "vec_grant");
    check("R2", int'(vec_simd), (ev >= 0) ? m_turn : 0, "vec_simd");
    check(cur_tag, int'(vec_slot), (ev >= 0) ? ev : 0, "vec_slot");
    check("R5", int'(sc_grant), int'(es >= 0), "sc_grant");
    check("R5", int'(sc_simd), (es >= 0) ? m_turn : 0, "sc_simd");
    check("R5", int'(sc_slot), (es >= 0) ? es : 0, "sc_slot");
    check("R8", int'(idle_count), m_idle, "idle_count");
    // advance the model to the next cycle
    for (int f = 0; f < NT; f++) begin
      bit iss = (ev >= 0 && f == m_turn*NSL+ev) || (es >= 0 && f == m_turn*NSL+es);
      if (!s_valid[f]) begin m_pend[f] = 0; m_age[f] = 0; end
      else begin
        if (m_age[f] < AGE_MAX) m_age[f]++;
        if (iss) m_pend[f] = 1;
        else if (s_done[f]) m_pend[f] = 0;
      end
    end
    if (ev < 0 && es < 0 && m_idle < IDLE_MAX) m_idle++;
    m_turn = (m_turn + 1) % NS;
    cyc++;
  endtask

  // mode: 0 staggered age, 1 dep stalls, 2 no completions, 3 mixed class, 4 churn
  task automatic drive(int mode, int step);
    for (int f = 0; f < NT; f++) begin
      int s = f % NSL;
      case (mode)
        0: begin
          s_valid[f]  = (step >= (NSL-1-s)*6);
          s_ready[f]  = 1'b1; s_dep[f] = 1'b1; s_scalar[f] = 1'b0;
          s_done[f]   = m_pend[f];
        end
        1: begin
          s_valid[f]  = 1'b1; s_ready[f] = 1'b1; s_scalar[f] = 1'b0;
          s_dep[f]    = ($urandom_range(9) < 3);
          s_done[f]   = m_pend[f] && ($urandom_range(2) == 0);
        end
        2: begin
          s_valid[f]  = 1'b1; s_ready[f] = 1'b1; s_dep[f] = 1'b1;
          s_scalar[f] = (s == 3);
          s_done[f]   = !m_pend[f] && ($urandom_range(3) == 0);
        end
        3: begin
          s_valid[f]  = 1'b1; s_ready[f] = ($urandom_range(3) != 0);
          s_dep[f]    = ($urandom_range(3) != 0);
          s_scalar[f] = ($urandom_range(1) == 0);
          s_done[f]   = m_pend[f] && ($urandom_range(1) == 0);
        end
        default: begin
          if ($urandom_range(19) == 0) s_valid[f] = ~s_valid[f];
          s_ready[f]  = ($urandom_range(1) == 0);
          s_dep[f]    = ($urandom_range(3) != 0);
          s_scalar[f] = ($urandom_range(4) == 0);
          s_done[f]   = ($urandom_range(2) == 0);
        end
      endcase
    end
  endtask

  task automatic run(int mode, int n, string tag);
    cur_tag = tag;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      drive(mode, k);
      #4;
      compare_and_step();
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    s_valid = '1; s_ready = '1; s_scalar = 40'h00F0_0F00_F0; s_dep = '1; s_done = '0;
    cyc = 0; m_turn = 0; m_idle = 0;
    for (int f = 0; f < NT; f++) begin m_age[f] = 0; m_pend[f] = 0; end
    // R1: held in reset with every slot ready
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #4;
      check("R1", int'(vec_grant), 0, "vec_grant in reset");
      check("R1", int'(sc_grant), 0, "sc_grant in reset");
      check("R1", int'(idle_count), 0, "idle_count in reset");
    end
    @(negedge clk);
    rst_n = 1'b1;
    s_valid = '0;
    #4;
    check("R1", int'(vec_grant) + int'(sc_grant), 0, "no grant with empty slots");
    compare_and_step();
    run(0, 240, "R4");
    run(1, 400, "R7");
    run(2, 300, "R6");
    run(3, 500, "R5");
    run(4, 800, "R3");
    finish_up();
  end
endmodule